// File: doc/BRIEF.md
# Grouped Sub-Source Interrupt Combiner

This block sits in front of a main interrupt controller. It gathers eleven secondary interrupt requests into four primary request lines. Three serial channels each contribute a receive, a transmit and an error request. A data converter contributes a conversion-done request and a touch request. Each primary line is a registered level. It is the OR of the members of its group that are both pending and unmasked, taken at the most recent evaluation.

Software sees two registers through a small register port. One is the sub-source pending register; writing ones to it clears bits. The other is an 11-bit sub-mask, where a one hides a member. A parameter marks each sub-source as level type or pulse type. A level source is held for as long as its request line stays high. A pulse source is never held. After every evaluation the pending register is reloaded with the set of held level sources, so a pulse source acts at exactly one evaluation.

An evaluation happens in three cases: a request line rises, the sub-mask is written, or a pending write targets a bit that is still held. Between evaluations the output lines keep their values. The register select has two named values. `SEL_PEND` (0) addresses the pending register and `SEL_MASK` (1) addresses the sub-mask. There is no sequencer. The only state is the pending, mask, previous-request and output registers.

Top module: `subint_combiner`

## Requirements
- R1: After reset the pending register reads 0, the sub-mask reads 0x7FF (all masked) and all four output lines are 0.
- R2: Sub-source bits are numbered 0 to 10. Bits 0,1,2 are the receive, transmit and error requests of serial channel 0, bits 3-5 belong to channel 1 and bits 6-8 to channel 2. At an evaluation, output line c (c = 0..2) becomes 1 exactly when one of its channel's bits is pending and unmasked. The line changes on the clock edge at which the evaluation happens.
- R3: At an evaluation, output line 3 becomes the OR of pending-and-unmasked bits 9 (conversion done) and 10 (touch).
- R4: A rising request line sets its pending bit and causes an evaluation on that clock edge.
- R5: After every evaluation the pending register holds exactly the set of level-type requests that are currently high. With the default parameters, bits 0-8 are level type and bits 9-10 are pulse type. A pulse request therefore drives its line only until the next evaluation.
- R6: A write of ones to the pending register (select 0) clears those bits, except bits whose level request is still held. An evaluation follows only if a held bit was targeted.
- R7: A sub-mask write (select 1) keeps only data bits 10:0 and discards the upper bits. The write causes an evaluation that uses the new mask.
- R8: The read port returns the pending register for select 0 and the sub-mask for select 1, zero-extended to the data width.
- R9: Between evaluations the output lines do not change, even when a held level request drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_req | input | 11 | Sub-source request lines, bit numbering as in R2 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 pending (clear by ones), 1 sub-mask |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 pending, 1 sub-mask |
| rd_data | output | 32 | Read data, zero-extended |
| line_out | output | 4 | Primary lines: 0..2 serial channels, 3 converter |

## Verification
On every cycle, the assertions check four things: the reset value of the mask, the truncation of mask writes to 11 bits, the reload of pending with the held set after each evaluation, and that pending clears which touch no held bit leave those bits at zero. They also check that the output lines stay stable whenever no evaluation takes place. The directed scenarios are needed to show that the group mapping is correct: which sub-source bit drives which line, and that the converter pair shares one line. Only the scenarios can show a pulse request acting once and then vanishing at the next evaluation. They also show that a dropped level request leaves its line high until some later evaluation.

// File: rtl/subint_pkg.sv
package subint_pkg;
    localparam int CH_NUM  = 3;
    localparam int CH_SUBS = 3;
    localparam int CV_SUBS = 2;
    localparam int NSUB    = CH_NUM * CH_SUBS + CV_SUBS;
    localparam int NGRP    = CH_NUM + 1;

    typedef enum logic {
        SEL_PEND = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    function automatic int group_of(input int bit_idx);
        int g;
        g = bit_idx / CH_SUBS;
        if (g > CH_NUM) g = CH_NUM;
        return g;
    endfunction
endpackage

// File: rtl/subint_mask_reg.sv
module subint_mask_reg #(
    parameter int NSUB   = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NSUB-1:0]   mask_q
);
    localparam logic [NSUB-1:0] MASK_RST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= MASK_RST;
        else if (wr_mask) mask_q <= wr_data[NSUB-1:0];
    end

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> mask_q == $past(wr_data[NSUB-1:0]));

    always_ff @(posedge clk) begin
        if (rst_n && $past(rst_n) == 1'b0)
            assert_mask_reset_R1: assert ($past(mask_q) == MASK_RST || $past(wr_mask));
    end
endmodule

// File: rtl/subint_pend_reg.sv
module subint_pend_reg #(
    parameter int              NSUB       = 11,
    parameter logic [NSUB-1:0] LEVEL_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] sub_req,
    input  logic            clr_en,
    input  logic [NSUB-1:0] clr_data,
    input  logic            mask_wr,
    output logic [NSUB-1:0] pend_q,
    output logic [NSUB-1:0] pend_eval,
    output logic            eval
);
    logic [NSUB-1:0] req_q;
    logic [NSUB-1:0] held;
    logic [NSUB-1:0] rise;
    logic [NSUB-1:0] clr_vec;
    logic [NSUB-1:0] pend_d;
    logic            hit_held;

    always_comb begin
        held      = sub_req & LEVEL_MASK;
        rise      = sub_req & ~req_q;
        clr_vec   = clr_en ? clr_data : '0;
        hit_held  = clr_en && (|(clr_data & held));
        pend_eval = (pend_q & ~clr_vec) | (clr_en ? held : '0) | rise;
        eval      = (|rise) || mask_wr || hit_held;
        pend_d    = eval ? held : pend_eval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            req_q  <= '0;
        end else begin
            pend_q <= pend_d;
            req_q  <= sub_req;
        end
    end

    assert_reload_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> pend_q == $past(sub_req & LEVEL_MASK));

    assert_clear_unheld_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !eval) |=> ((pend_q & $past(clr_data)) == '0));
endmodule

// File: rtl/subint_group_or.sv
module subint_group_or
    import subint_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eval,
    input  logic [NSUB-1:0] svc,
    output logic [NGRP-1:0] line_q
);
    logic [NGRP-1:0] line_d;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [NSUB-1:0] member;
        for (genvar b = 0; b < NSUB; b++) begin : g_bit
            assign member[b] = (group_of(b) == g);
        end
        assign line_d[g] = |(svc & member);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else if (eval) line_q <= line_d;
    end

    assert_hold_between_evals_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(line_q));
endmodule

// File: rtl/subint_combiner.sv
module subint_combiner
    import subint_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter logic [NSUB-1:0] LEVEL_MASK = 11'h1FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSUB-1:0]   sub_req,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [NGRP-1:0]   line_out
);
    logic            wr_mask;
    logic            wr_pend;
    logic [NSUB-1:0] mask_q;
    logic [NSUB-1:0] mask_eff;
    logic [NSUB-1:0] pend_q;
    logic [NSUB-1:0] pend_eval;
    logic [NSUB-1:0] svc;
    logic            eval;

    always_comb begin
        wr_mask  = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
        wr_pend  = wr_en && (reg_sel_e'(wr_sel) == SEL_PEND);
        mask_eff = wr_mask ? wr_data[NSUB-1:0] : mask_q;
        svc      = pend_eval & ~mask_eff;
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_PEND: rd_data[NSUB-1:0] = pend_q;
            SEL_MASK: rd_data[NSUB-1:0] = mask_q;
        endcase
    end

    subint_mask_reg #(.NSUB(NSUB), .DATA_W(DATA_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .mask_q  (mask_q)
    );

    subint_pend_reg #(.NSUB(NSUB), .LEVEL_MASK(LEVEL_MASK)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_req   (sub_req),
        .clr_en    (wr_pend),
        .clr_data  (wr_data[NSUB-1:0]),
        .mask_wr   (wr_mask),
        .pend_q    (pend_q),
        .pend_eval (pend_eval),
        .eval      (eval)
    );

    subint_group_or u_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval   (eval),
        .svc    (svc),
        .line_q (line_out)
    );

    assert_rise_evaluates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sub_req & ~$past(sub_req))) |-> eval);
endmodule

// File: tb/subint_combiner_test.sv
module subint_combiner_test;
    import subint_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSUB-1:0]   sub_req = '0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_sel = 1'b0;
    logic [31:0]       rd_data;
    logic [NGRP-1:0]   line_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    subint_combiner uut (
        .clk(clk), .rst_n(rst_n), .sub_req(sub_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .line_out(line_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_req(input int b, input logic v);
        @(negedge clk);
        sub_req[b] = v;
        step();
    endtask

    task automatic read_pend(input string req, input logic [31:0] exp);
        rd_sel = 1'b0; #1; check(req, rd_data, exp);
    endtask

    task automatic read_mask(input string req, input logic [31:0] exp);
        rd_sel = 1'b1; #1; check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        read_pend("R1 pend", 32'h0);
        read_mask("R1 mask", 32'h7FF);
        check("R1 lines", {28'h0, line_out}, 32'h0);
    endtask

    task automatic t_unmask_channel0();
        set_req(1, 1'b1);
        check("R4 masked line", {28'h0, line_out}, 32'h0);
        read_pend("R4 pend set", 32'h002);
        reg_write(1'b1, 32'hFFFF_F7FD);
        check("R2 ch0 line", {28'h0, line_out}, 32'h1);
        read_mask("R7 upper dropped", 32'h7FD);
    endtask

    task automatic t_drop_without_eval();
        set_req(1, 1'b0);
        check("R9 line kept", {28'h0, line_out}, 32'h1);
        read_pend("R9 pend kept", 32'h002);
        reg_write(1'b0, 32'h002);
        read_pend("R6 unheld cleared", 32'h0);
        check("R6 no eval", {28'h0, line_out}, 32'h1);
        reg_write(1'b1, 32'h7FF);
        check("R7 mask eval", {28'h0, line_out}, 32'h0);
    endtask

    task automatic t_held_clear();
        set_req(4, 1'b1);
        reg_write(1'b1, 32'h7EF);
        check("R2 ch1 line", {28'h0, line_out}, 32'h2);
        reg_write(1'b0, 32'h010);
        read_pend("R6 held kept", 32'h010);
        check("R6 held line", {28'h0, line_out}, 32'h2);
        set_req(4, 1'b0);
        reg_write(1'b0, 32'h010);
        read_pend("R6 released cleared", 32'h0);
        check("R6 released no eval", {28'h0, line_out}, 32'h2);
        reg_write(1'b1, 32'h7EF);
        check("R5 line drops", {28'h0, line_out}, 32'h0);
    endtask

    task automatic t_converter_pulse();
        reg_write(1'b1, 32'h5FF);
        set_req(9, 1'b1);
        check("R3 done line", {28'h0, line_out}, 32'h8);
        read_pend("R5 pulse not kept", 32'h0);
        @(negedge clk); sub_req[9] = 1'b0;
        reg_write(1'b1, 32'h3FF);
        check("R5 pulse gone", {28'h0, line_out}, 32'h0);
        set_req(10, 1'b1);
        check("R3 touch line", {28'h0, line_out}, 32'h8);
        @(negedge clk); sub_req[10] = 1'b0;
        reg_write(1'b1, 32'h7FF);
        check("R3 masked again", {28'h0, line_out}, 32'h0);
    endtask

    task automatic t_multi_channel();
        reg_write(1'b1, 32'h000);
        @(negedge clk);
        sub_req[2] = 1'b1; sub_req[8] = 1'b1;
        step();
        check("R2 ch0+ch2", {28'h0, line_out}, 32'h5);
        read_pend("R8 pend read", 32'h104);
        @(negedge clk);
        sub_req[2] = 1'b0; sub_req[8] = 1'b0;
        reg_write(1'b1, 32'h7FF);
        read_pend("R5 reload empty", 32'h0);
        check("R2 all low", {28'h0, line_out}, 32'h0);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_unmask_channel0();
        t_drop_without_eval();
        t_held_clear();
        t_converter_pulse();
        t_multi_channel();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule